// File: doc/BRIEF.md
# Four-Channel Compare-Match PWM Timer

This block holds four independent 16-bit timer channels behind a small memory-mapped register port. Each channel counts on a selectable edge of a prescaled clock, compares its counter against four compare registers, and can reset the counter when a chosen compare register matches. Every channel owns one output pin. In normal mode a match on compare register A clears, sets or toggles the pin. In PWM mode the pin leaves its start level at the A match and comes back to it when the counter-reset match occurs. So the reset register sets the period and register A sets the duty.

A shared start register has one run bit per channel. A stopped channel freezes both its counter and its pin. A new start level written to a channel's pin-control register only reaches the pin while the channel runs, or when the channel is started. Software therefore runs a channel briefly whenever it needs to park the pin at a fixed level.

Top module: `cmp_pwm_timer`

## Requirements
- R1: After reset every register reads 0, every counter is 0 and every pin is low.
- R2: Bit n of the start register at byte address 0x00 runs channel n (1) or stops it (0). It reads back with the upper bits as 0. A stopped counter keeps its value, and counting resumes from that value when the channel restarts.
- R3: Channel n occupies addresses 0x10 + 0x40*n. Relative to that base, control is at 0x00, mode at 0x04, pin control at 0x08, counter at 0x14 and compare A, B, C, D at 0x18, 0x1C, 0x20, 0x24. All are 16 bits wide and read back whole. Read data is registered, so it is valid one cycle after the address. Any other address reads 0 and ignores writes.
- R4: Control bits [1:0] = p give one count for every 4^p clock cycles when rising-edge counting is selected.
- R5: Control bits [4:3] select the counting edge of the divided clock. Code 1 (falling) counts at the same rate as code 0 (rising), and code 3 also behaves as rising. Code 2 (both) doubles the rate when p > 0. With p = 0 the channel counts once per cycle whatever the edge code.
- R6: Control bits [7:5] pick the counter reset source: 1 is match on A, 2 on B, 5 on C, 6 on D. Every other code means no reset. A counting edge with the counter equal to the selected register K loads 0, which gives a period of K+1 counts. Without a reset source the counter wraps from 0xFFFF to 0.
- R7: When mode bits [1:0] are not 2, a counting edge with the counter equal to A applies pin-control bits [1:0]: 0 leaves the pin, 1 drives it low, 2 drives it high, 3 toggles it.
- R8: With mode bits [1:0] = 2, the pin takes the R7 action at the A match and returns to pin-control bit 2 at the counter-reset match. When both matches fall on the same edge, the return wins.
- R9: Pin-control bit 2 is copied to the pin when pin control is written while the channel runs, and when the channel's start bit goes from 0 to 1. While the channel is stopped the pin does not change.
- R10: A write to compare A while the channel runs is used from the next counting edge, with no buffering.
- R11: A bus write to the counter takes priority over counting on that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 16 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 16 | Registered read data for the previous cycle's address |
| pin_o | output | 4 | Channel output pins, bit n for channel n |

## Verification
A register write takes effect at the clock edge where the strobe is high. Read data appears one edge after the address is presented, so the bench samples it on the next falling edge. A started channel first counts on the edge after its start write, and the last edge it counts on is the one that stops it. The bench therefore frames rate and clear tests as windows of exactly 64 counting edges. Because the prescaler pattern repeats every 64 cycles, the expected count does not depend on prescaler phase. Pin checks either trace the PWM waveform edge by edge from the start write, or count high samples over whole periods once the pin has settled. A counter read taken while the channel runs is expected to show the value from one edge later than the write.

// File: rtl/cmpt_pkg.sv
package cmpt_pkg;
  localparam int NUM_CMP  = 4;
  localparam int PS_MAX   = 3;
  localparam int DIV_W    = 2 * PS_MAX;
  localparam int CH_BASE  = 'h10;
  localparam int CH_SHIFT = 6;

  typedef enum logic [3:0] {
    R_NONE, R_CTL, R_MODE, R_PIN, R_CNT, R_CA, R_CB, R_CC, R_CD
  } reg_e;

  localparam logic [2:0] CLR_A = 3'd1;
  localparam logic [2:0] CLR_B = 3'd2;
  localparam logic [2:0] CLR_C = 3'd5;
  localparam logic [2:0] CLR_D = 3'd6;
  localparam logic [1:0] MODE_PWM  = 2'd2;
  localparam logic [1:0] EDGE_FALL = 2'd1;
  localparam logic [1:0] EDGE_BOTH = 2'd2;
  localparam logic [1:0] ACT_LOW   = 2'd1;
  localparam logic [1:0] ACT_HIGH  = 2'd2;
  localparam logic [1:0] ACT_TGL   = 2'd3;

  // Counting edge of the divided clock, derived from a shared free-running divider.
  function automatic logic cnt_tick(input logic [1:0] ps, input logic [1:0] edg,
                                    input logic [DIV_W-1:0] div);
    logic [DIV_W-1:0] mask, half, low;
    logic rise, fall, res;
    mask = (DIV_W'(1) << {ps, 1'b0}) - DIV_W'(1);
    half = DIV_W'(1) << ({ps, 1'b0} - 3'd1);
    low  = div & mask;
    rise = (low == '0);
    fall = (low == half);
    if (ps == 2'd0)             res = 1'b1;
    else if (edg == EDGE_FALL)  res = fall;
    else if (edg == EDGE_BOTH)  res = rise | fall;
    else                        res = rise;
    return res;
  endfunction
endpackage

// File: rtl/cmpt_prescale.sv
module cmpt_prescale import cmpt_pkg::*; (
  input  logic             clk,
  input  logic             rst,
  output logic [DIV_W-1:0] div
);
  logic [DIV_W-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst) div_q <= '0;
    else     div_q <= div_q + DIV_W'(1);
  end

  assign div = div_q;
endmodule

// File: rtl/cmpt_regdec.sv
module cmpt_regdec import cmpt_pkg::*; #(
  parameter int NUM_CH = 4,
  parameter int AW     = 8
) (
  input  logic [AW-1:0]     addr,
  output logic              start_hit,
  output logic [NUM_CH-1:0] ch_sel,
  output reg_e              reg_sel
);
  localparam int CH_IW = AW - CH_SHIFT;

  logic [AW-1:0]       off;
  logic [CH_IW-1:0]    idx;
  logic [CH_SHIFT-1:0] roff;
  logic                in_range;
  reg_e                r;

  assign off       = addr - AW'(CH_BASE);
  assign idx       = off[AW-1:CH_SHIFT];
  assign roff      = off[CH_SHIFT-1:0];
  assign in_range  = (addr >= AW'(CH_BASE)) && (int'(idx) < NUM_CH);
  assign start_hit = (addr == '0);

  always_comb begin
    case (roff)
      6'h00:   r = R_CTL;
      6'h04:   r = R_MODE;
      6'h08:   r = R_PIN;
      6'h14:   r = R_CNT;
      6'h18:   r = R_CA;
      6'h1C:   r = R_CB;
      6'h20:   r = R_CC;
      6'h24:   r = R_CD;
      default: r = R_NONE;
    endcase
  end

  assign reg_sel = in_range ? r : R_NONE;

  generate
    for (genvar n = 0; n < NUM_CH; n++) begin : g_sel
      assign ch_sel[n] = in_range && (idx == CH_IW'(n));
    end
  endgenerate
endmodule

// File: rtl/cmpt_channel.sv
module cmpt_channel import cmpt_pkg::*; #(
  parameter int DW = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  reg_e             reg_sel,
  input  logic [DW-1:0]    wdata,
  input  logic             run,
  input  logic             start_pulse,
  input  logic [DIV_W-1:0] div,
  output logic [DW-1:0]    rd_val,
  output logic             pin_o
);
  logic [DW-1:0] ctl_q, mode_q, pinc_q, cnt_q;
  logic [DW-1:0] cmp_q [NUM_CMP];
  logic [NUM_CMP-1:0] match, cmp_wr;
  logic tick, clr_hit, pwm, cnt_wr, pin_wr, pin_q;

  assign tick   = run && cnt_tick(ctl_q[1:0], ctl_q[4:3], div);
  assign pwm    = (mode_q[1:0] == MODE_PWM);
  assign cnt_wr = wr_en && (reg_sel == R_CNT);
  assign pin_wr = wr_en && (reg_sel == R_PIN);

  generate
    for (genvar k = 0; k < NUM_CMP; k++) begin : g_match
      assign match[k] = (cnt_q == cmp_q[k]);
    end
  endgenerate

  always_comb begin
    cmp_wr = '0;
    case (reg_sel)
      R_CA: cmp_wr[0] = wr_en;
      R_CB: cmp_wr[1] = wr_en;
      R_CC: cmp_wr[2] = wr_en;
      R_CD: cmp_wr[3] = wr_en;
      default: cmp_wr = '0;
    endcase
  end

  always_comb begin
    case (ctl_q[7:5])
      CLR_A:   clr_hit = match[0];
      CLR_B:   clr_hit = match[1];
      CLR_C:   clr_hit = match[2];
      CLR_D:   clr_hit = match[3];
      default: clr_hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q  <= '0;
      mode_q <= '0;
      pinc_q <= '0;
      cnt_q  <= '0;
      pin_q  <= 1'b0;
      for (int k = 0; k < NUM_CMP; k++) cmp_q[k] <= '0;
    end else begin
      if (wr_en && reg_sel == R_CTL)  ctl_q  <= wdata;
      if (wr_en && reg_sel == R_MODE) mode_q <= wdata;
      if (pin_wr)                     pinc_q <= wdata;
      for (int k = 0; k < NUM_CMP; k++)
        if (cmp_wr[k]) cmp_q[k] <= wdata;

      if (cnt_wr)    cnt_q <= wdata;
      else if (tick) cnt_q <= clr_hit ? '0 : cnt_q + DW'(1);

      if (pin_wr && run)    pin_q <= wdata[2];
      else if (start_pulse) pin_q <= pinc_q[2];
      else if (tick) begin
        if (pwm && clr_hit) pin_q <= pinc_q[2];
        else if (match[0]) begin
          case (pinc_q[1:0])
            ACT_LOW:  pin_q <= 1'b0;
            ACT_HIGH: pin_q <= 1'b1;
            ACT_TGL:  pin_q <= ~pin_q;
            default:  pin_q <= pin_q;
          endcase
        end
      end
    end
  end

  always_comb begin
    case (reg_sel)
      R_CTL:   rd_val = ctl_q;
      R_MODE:  rd_val = mode_q;
      R_PIN:   rd_val = pinc_q;
      R_CNT:   rd_val = cnt_q;
      R_CA:    rd_val = cmp_q[0];
      R_CB:    rd_val = cmp_q[1];
      R_CC:    rd_val = cmp_q[2];
      R_CD:    rd_val = cmp_q[3];
      default: rd_val = '0;
    endcase
  end

  assign pin_o = pin_q;

  assert_hold_stopped_R2: assert property (@(posedge clk) disable iff (rst)
    (!run && !cnt_wr) |=> $stable(cnt_q));

  assert_clear_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (tick && clr_hit && !cnt_wr) |=> (cnt_q == '0));

  assert_pwm_restore_R8: assert property (@(posedge clk) disable iff (rst)
    (tick && pwm && clr_hit && !pin_wr && !start_pulse) |=> (pin_q == $past(pinc_q[2])));

  assert_pin_frozen_R9: assert property (@(posedge clk) disable iff (rst)
    (!run && !start_pulse) |=> $stable(pin_q));
endmodule

// File: rtl/cmp_pwm_timer.sv
module cmp_pwm_timer import cmpt_pkg::*; #(
  parameter int NUM_CH = 4,
  parameter int DW     = 16,
  parameter int AW     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  input  logic              bus_we,
  output logic [DW-1:0]     bus_rdata,
  output logic [NUM_CH-1:0] pin_o
);
  logic              start_hit;
  logic [NUM_CH-1:0] ch_sel, run_q, start_pulse;
  reg_e              reg_sel;
  logic [DIV_W-1:0]  div;
  logic [DW-1:0]     ch_rd [NUM_CH];
  logic [DW-1:0]     rd_mux, rdata_q;

  cmpt_regdec #(.NUM_CH(NUM_CH), .AW(AW)) u_dec (
    .addr(bus_addr), .start_hit(start_hit), .ch_sel(ch_sel), .reg_sel(reg_sel)
  );

  cmpt_prescale u_ps (.clk(clk), .rst(rst), .div(div));

  always_ff @(posedge clk) begin
    if (rst)                      run_q <= '0;
    else if (start_hit && bus_we) run_q <= bus_wdata[NUM_CH-1:0];
  end

  assign start_pulse = {NUM_CH{start_hit && bus_we}} & bus_wdata[NUM_CH-1:0] & ~run_q;

  generate
    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
      cmpt_channel #(.DW(DW)) u_ch (
        .clk(clk), .rst(rst),
        .wr_en(bus_we && ch_sel[n]),
        .reg_sel(reg_sel),
        .wdata(bus_wdata),
        .run(run_q[n]),
        .start_pulse(start_pulse[n]),
        .div(div),
        .rd_val(ch_rd[n]),
        .pin_o(pin_o[n])
      );
    end
  endgenerate

  always_comb begin
    rd_mux = '0;
    if (start_hit) rd_mux = DW'(run_q);
    for (int n = 0; n < NUM_CH; n++)
      if (ch_sel[n]) rd_mux = ch_rd[n];
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_mux;
  end

  assign bus_rdata = rdata_q;

  assert_decode_onehot_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({start_hit, ch_sel}));

  assert_start_readback_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == '0) |=> (bus_rdata == DW'($past(run_q))));
endmodule

// File: tb/sim_cmp_pwm_timer.sv
module sim_cmp_pwm_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic        we = 1'b0;
  logic [15:0] rdata;
  logic [3:0]  pin;
  int errors = 0;
  int checks = 0;

  localparam logic [7:0] O_CTL = 8'h00, O_MODE = 8'h04, O_PIN = 8'h08, O_CNT = 8'h14,
                         O_A = 8'h18, O_B = 8'h1C, O_C = 8'h20, O_D = 8'h24;

  cmp_pwm_timer u0 (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_wdata(wdata),
    .bus_we(we), .bus_rdata(rdata), .pin_o(pin)
  );

  always #4 clk = ~clk;

  function automatic logic [7:0] base(input int ch);
    return 8'h10 + 8'(ch) * 8'h40;
  endfunction

  function automatic logic [7:0] offs(input int i);
    case (i)
      0: return O_CTL; 1: return O_MODE; 2: return O_PIN; 3: return O_CNT;
      4: return O_A;   5: return O_B;    6: return O_C;   default: return O_D;
    endcase
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] v);
    @(negedge clk); addr = a;
    @(negedge clk); v = rdata;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; we = 1'b0; addr = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // 64 counting edges between start and stop writes
  task automatic run_window(input int ch);
    wr(8'h00, 16'(1 << ch));
    repeat (62) @(negedge clk);
    wr(8'h00, 16'h0000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] v, v2;
    int hi;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 pins", {12'h0, pin}, 16'h0);
    rd(8'h00, v); chk("R1 start", v, 16'h0);
    for (int ch = 0; ch < 4; ch++)
      for (int i = 0; i < 8; i++) begin
        rd(base(ch) + offs(i), v); chk("R1 reg", v, 16'h0);
      end

    // R3 register map sweep
    for (int ch = 0; ch < 4; ch++)
      for (int i = 0; i < 8; i++)
        wr(base(ch) + offs(i), 16'h1000 * 16'(ch) + 16'h0101 * 16'(i + 1));
    for (int ch = 0; ch < 4; ch++) begin
      for (int i = 0; i < 8; i++) begin
        rd(base(ch) + offs(i), v);
        chk("R3 readback", v, 16'h1000 * 16'(ch) + 16'h0101 * 16'(i + 1));
      end
      wr(base(ch) + 8'h0C, 16'hFFFF); rd(base(ch) + 8'h0C, v); chk("R3 unmapped 0C", v, 16'h0);
      wr(base(ch) + 8'h10, 16'hFFFF); rd(base(ch) + 8'h10, v); chk("R3 unmapped 10", v, 16'h0);
      wr(base(ch) + 8'h28, 16'hFFFF); rd(base(ch) + 8'h28, v); chk("R3 unmapped 28", v, 16'h0);
      rd(base(ch) + O_CTL, v); chk("R3 no alias", v, 16'h1000 * 16'(ch) + 16'h0101);
    end
    wr(8'h04, 16'hFFFF); rd(8'h04, v); chk("R3 gap 04", v, 16'h0);
    chk("R9 pins frozen while stopped", {12'h0, pin}, 16'h0);
    do_reset();

    // R4 / R5 prescale and edge sweep on channel 0
    for (int p = 0; p < 4; p++)
      for (int e = 0; e < 4; e++) begin
        int exp_cnt;
        exp_cnt = (p == 0) ? 64 : ((e == 2) ? 2 * (64 >> (2 * p)) : (64 >> (2 * p)));
        wr(base(0) + O_CTL, 16'((e << 3) | p));
        wr(base(0) + O_CNT, 16'h0);
        run_window(0);
        rd(base(0) + O_CNT, v);
        chk((e == 0) ? "R4 prescale rate" : "R5 edge rate", v, 16'(exp_cnt));
      end

    // R2 hold while stopped, resume
    wr(base(0) + O_CTL, 16'h0);
    wr(base(0) + O_CNT, 16'h0);
    run_window(0);
    rd(base(0) + O_CNT, v); chk("R2 first window", v, 16'd64);
    repeat (20) @(negedge clk);
    rd(base(0) + O_CNT, v); chk("R2 held while stopped", v, 16'd64);
    run_window(0);
    rd(base(0) + O_CNT, v); chk("R2 resumed", v, 16'd128);

    // R6 reset source sweep on channel 1, A..D = 5..8
    wr(base(1) + O_A, 16'd5); wr(base(1) + O_B, 16'd6);
    wr(base(1) + O_C, 16'd7); wr(base(1) + O_D, 16'd8);
    for (int s = 0; s < 8; s++) begin
      int exp_cnt;
      case (s)
        1: exp_cnt = 64 % 6;
        2: exp_cnt = 64 % 7;
        5: exp_cnt = 64 % 8;
        6: exp_cnt = 64 % 9;
        default: exp_cnt = 64;
      endcase
      wr(base(1) + O_CTL, 16'(s << 5));
      wr(base(1) + O_CNT, 16'h0);
      run_window(1);
      rd(base(1) + O_CNT, v); chk("R6 clear source", v, 16'(exp_cnt));
    end
    wr(base(1) + O_CTL, 16'h0);
    wr(base(1) + O_CNT, 16'hFFF0);
    run_window(1);
    rd(base(1) + O_CNT, v); chk("R6 wrap", v, 16'h0030);

    // R7 normal-mode actions on channel 2, A = 3
    wr(base(2) + O_A, 16'd3);
    for (int code = 0; code < 8; code++) begin
      logic b, res;
      b = code[2];
      case (code[1:0])
        2'd0: res = b;
        2'd1: res = 1'b0;
        2'd2: res = 1'b1;
        default: res = ~b;
      endcase
      wr(base(2) + O_CNT, 16'h0);
      wr(base(2) + O_PIN, 16'(code));
      wr(8'h00, 16'h0004);
      chk("R9 start loads level", {15'h0, pin[2]}, {15'h0, b});
      repeat (10) @(negedge clk);
      chk("R7 match action", {15'h0, pin[2]}, {15'h0, res});
      wr(8'h00, 16'h0000);
    end

    // R8 PWM waveform on channel 3: reset on B=5, A=2, start low, set at A
    wr(base(3) + O_CTL, 16'(2 << 5));
    wr(base(3) + O_MODE, 16'd2);
    wr(base(3) + O_A, 16'd2);
    wr(base(3) + O_B, 16'd5);
    wr(base(3) + O_PIN, 16'd2);
    wr(base(3) + O_CNT, 16'h0);
    wr(8'h00, 16'h0008);
    for (int m = 1; m <= 24; m++) begin
      if (m > 1) @(negedge clk);
      chk("R8 pwm trace", {15'h0, pin[3]}, {15'h0, ((m - 1) % 6) >= 3});
    end
    // R10 duty change while running
    wr(base(3) + O_A, 16'd4);
    repeat (8) @(negedge clk);
    hi = 0;
    for (int m = 0; m < 12; m++) begin @(negedge clk); hi += int'(pin[3]); end
    chk("R10 new duty", 16'(hi), 16'd2);
    // R8 coincident matches: restore wins
    wr(base(3) + O_A, 16'd5);
    repeat (8) @(negedge clk);
    hi = 0;
    for (int m = 0; m < 12; m++) begin @(negedge clk); hi += int'(pin[3]); end
    chk("R8 coincident", 16'(hi), 16'd0);
    // R8 inverted: start high, clear at A
    wr(base(3) + O_A, 16'd2);
    wr(base(3) + O_PIN, 16'd5);
    repeat (8) @(negedge clk);
    hi = 0;
    for (int m = 0; m < 12; m++) begin @(negedge clk); hi += int'(pin[3]); end
    chk("R8 inverted", 16'(hi), 16'd6);
    wr(8'h00, 16'h0000);

    // R9 level writes on channel 2
    wr(base(2) + O_A, 16'hFFFF);
    wr(base(2) + O_PIN, 16'h0);
    wr(base(2) + O_CNT, 16'h0);
    wr(8'h00, 16'h0004);
    chk("R9 start low", {15'h0, pin[2]}, 16'h0);
    wr(base(2) + O_PIN, 16'h4);
    chk("R9 write while running high", {15'h0, pin[2]}, 16'h1);
    wr(base(2) + O_PIN, 16'h0);
    chk("R9 write while running low", {15'h0, pin[2]}, 16'h0);
    wr(8'h00, 16'h0000);
    wr(base(2) + O_PIN, 16'h4);
    repeat (5) @(negedge clk);
    chk("R9 write while stopped ignored", {15'h0, pin[2]}, 16'h0);
    wr(8'h00, 16'h0004);
    chk("R9 applied at start", {15'h0, pin[2]}, 16'h1);
    wr(8'h00, 16'h0000);

    // R11 counter write while running
    wr(base(0) + O_CTL, 16'h0);
    wr(8'h00, 16'h0001);
    repeat (3) @(negedge clk);
    wr(base(0) + O_CNT, 16'h1000);
    rd(base(0) + O_CNT, v);
    chk("R11 counter write wins", v, 16'h1001);
    wr(8'h00, 16'h0000);
    rd(base(0) + O_CNT, v);
    repeat (4) @(negedge clk);
    rd(base(0) + O_CNT, v2);
    chk("R2 stopped after write", v2, v);

    // R2 start register readback
    wr(8'h00, 16'hFFF5);
    rd(8'h00, v); chk("R2 start readback", v, 16'h0005);
    wr(8'h00, 16'h0000);
    rd(8'h00, v); chk("R2 start cleared", v, 16'h0000);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule